// File: doc/BRIEF.md
# NAND Bus Width Adapter

This block sits between a processor-side access port and a raw NAND bus. A request names one of three ports (data, command or address), an access size of one, two or four bytes, a direction and write data. The adapter breaks the access into one or more bus beats on an 8-bit or 16-bit NAND bus. Beats go out least significant part first. Command writes raise the command latch flag and address writes raise the address latch flag. Read beats are gathered little-endian into a result word, which is returned with a one-clock completion pulse.

Both sides use valid/ready. The request side accepts one access when `req_valid` and `req_ready` are both high. `req_ready` is high only while the adapter is idle, so a request presented during a transfer or during its completion cycle waits, and its fields must stay stable until it is accepted. On the bus side, `nand_valid` stays high, with stable data and flags, until the device returns `nand_ready`. Each valid-and-ready edge retires one beat, and the next beat only starts after that. Bus width is sampled from a configuration input when the request is accepted.

Top module: `nand_width_adapter`

## Requirements
- R1: `req_ready` is high exactly when no access is in progress or completing. An access is accepted on a clock edge where `req_valid` and `req_ready` are both high. While `nand_valid` is high and `nand_ready` is low, `nand_dout`, `nand_we`, `nand_cle` and `nand_ale` hold their values.
- R2: With an 8-bit bus, a size code of 0, 1 or 2 (1, 2 or 4 bytes) takes 1, 2 or 4 beats. Beat k carries byte k of the write data on `nand_dout[7:0]`, with `nand_dout[15:8]` zero.
- R3: With a 16-bit bus, size codes 0 and 1 take one beat and size code 2 takes two beats. Beat k carries bits [16k+15:16k] of the write data.
- R4: A 1-byte read on a 16-bit bus returns only `nand_din[7:0]` of its single beat, and `rsp_rdata[31:8]` is zero.
- R5: A 1-byte write on a 16-bit bus drives all of `req_wdata[15:0]` in its single beat.
- R6: Port code 1 (command) asserts `nand_cle` only, on writes. Port code 2 (address) asserts `nand_ale` only, on writes. Port codes 0 and 3 (data), and every read, assert neither flag. Both flags are zero whenever `nand_valid` is low.
- R7: `dev_cfg[0]` = 1 selects the 16-bit bus and 0 selects the 8-bit bus. `dev_cfg[1]` has no effect.
- R8: On reads, read beat k is placed at bit offset 8k (8-bit bus) or 16k (16-bit bus) of `rsp_rdata`. Bits the access does not cover are zero. Writes return `rsp_rdata` = 0.
- R9: `rsp_done` is high for exactly one clock. That clock is the one right after the edge where the last beat's handshake completes, and `nand_valid` is low during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_cfg | input | 2 | Bus width configuration; bit 0 selects 16-bit |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Adapter can accept an access |
| req_port | input | 2 | 0 data, 1 command, 2 address, 3 data |
| req_size | input | 2 | 0 one byte, 1 two bytes, 2 or 3 four bytes |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 32 | Assembled read data, valid with rsp_done |
| nand_valid | output | 1 | Bus beat strobe |
| nand_ready | input | 1 | Device accepts the current beat |
| nand_we | output | 1 | Beat direction, 1 for write |
| nand_cle | output | 1 | Command latch flag |
| nand_ale | output | 1 | Address latch flag |
| nand_dout | output | 16 | Bus write data |
| nand_din | input | 16 | Bus read data |

## Verification
Two things can land on the same cycle: the completion pulse of one access and the arrival of the next request. The bench raises a new read request in the very cycle where `rsp_done` of a command write is high. It expects `req_ready` to be low there and high one clock later. It then expects the second access to start with its own beats and flags, with nothing left over from the first. A second overlap comes from stalling `nand_ready` for several cycles on a beat. Every stalled cycle is compared with the expected beat, so held outputs and beat ordering are judged together.

// File: rtl/nwa_pkg.sv
package nwa_pkg;
  typedef enum logic [1:0] {
    PORT_DATA = 2'd0,
    PORT_CMD  = 2'd1,
    PORT_ADDR = 2'd2,
    PORT_ALT  = 2'd3
  } port_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_DONE = 2'd2
  } state_e;
endpackage

// File: rtl/nwa_beat_plan.sv
module nwa_beat_plan #(
  parameter int DW = 32,
  localparam int BYTES = DW / 8,
  localparam int CW = $clog2(BYTES) + 1
) (
  input  logic [1:0]    size,
  input  logic          wide,
  output logic [CW-1:0] beats
);
  int nbytes;
  always_comb begin
    if (int'(size) >= $clog2(BYTES)) nbytes = BYTES;
    else nbytes = 1 << size;
    if (wide) beats = CW'((nbytes + 1) / 2);
    else beats = CW'(nbytes);
  end
endmodule

// File: rtl/nwa_lane_sel.sv
module nwa_lane_sel #(
  parameter int DW = 32,
  parameter int BW = 16,
  localparam int IW = $clog2(DW / 8)
) (
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] idx,
  input  logic          wide,
  output logic [BW-1:0] dout
);
  logic [DW-1:0] narrow_sh, wide_sh;
  always_comb begin
    narrow_sh = wdata >> {idx, 3'b000};
    wide_sh   = wdata >> {idx, 4'b0000};
    if (wide) dout = wide_sh[BW-1:0];
    else dout = {{(BW-8){1'b0}}, narrow_sh[7:0]};
  end
endmodule

// File: rtl/nwa_read_acc.sv
module nwa_read_acc #(
  parameter int DW = 32,
  parameter int BW = 16,
  localparam int IW = $clog2(DW / 8)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          take,
  input  logic          wide,
  input  logic          byte_only,
  input  logic [IW-1:0] idx,
  input  logic [BW-1:0] din,
  output logic [DW-1:0] acc
);
  logic [DW-1:0] lane;
  always_comb begin
    if (wide && !byte_only)
      lane = {{(DW-BW){1'b0}}, din} << {idx, 4'b0000};
    else if (wide)
      lane = {{(DW-8){1'b0}}, din[7:0]} << {idx, 4'b0000};
    else
      lane = {{(DW-8){1'b0}}, din[7:0]} << {idx, 3'b000};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) acc <= '0;
    else if (take) acc <= acc | lane;
  end
endmodule

// File: rtl/nand_width_adapter.sv
module nand_width_adapter
  import nwa_pkg::*;
#(
  parameter int DW = 32,
  parameter int BW = 16,
  localparam int IW = $clog2(DW / 8),
  localparam int CW = $clog2(DW / 8) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    dev_cfg,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_port,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic          nand_valid,
  input  logic          nand_ready,
  output logic          nand_we,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic [BW-1:0] nand_dout,
  input  logic [BW-1:0] nand_din
);
  state_e        state;
  port_e         port_q;
  logic          wr_q, wide_q, byte_q;
  logic [DW-1:0] wdata_q;
  logic [IW-1:0] idx;
  logic [CW-1:0] beats_q, beats_new;
  logic [DW-1:0] acc;
  logic          cfg_unused;
  logic          accept, beat_hs, last_beat;

  assign cfg_unused = dev_cfg[1];
  assign accept     = req_valid && req_ready;
  assign beat_hs    = nand_valid && nand_ready;
  assign last_beat  = (CW'(idx) + CW'(1)) == beats_q;

  nwa_beat_plan #(.DW(DW)) u_plan (
    .size (req_size),
    .wide (dev_cfg[0]),
    .beats(beats_new)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      port_q  <= PORT_DATA;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      byte_q  <= 1'b0;
      wdata_q <= '0;
      beats_q <= '0;
      idx     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_BUS;
          port_q  <= port_e'(req_port);
          wr_q    <= req_write;
          wide_q  <= dev_cfg[0];
          byte_q  <= (req_size == 2'd0);
          wdata_q <= req_wdata;
          beats_q <= beats_new;
          idx     <= '0;
        end
        ST_BUS: if (beat_hs) begin
          if (last_beat) state <= ST_DONE;
          else idx <= idx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  nwa_lane_sel #(.DW(DW), .BW(BW)) u_lane (
    .wdata(wdata_q),
    .idx  (idx),
    .wide (wide_q),
    .dout (nand_dout)
  );

  nwa_read_acc #(.DW(DW), .BW(BW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .take     (beat_hs && !wr_q),
    .wide     (wide_q),
    .byte_only(byte_q),
    .idx      (idx),
    .din      (nand_din),
    .acc      (acc)
  );

  assign req_ready  = (state == ST_IDLE);
  assign nand_valid = (state == ST_BUS);
  assign nand_we    = nand_valid && wr_q;
  assign nand_cle   = nand_we && (port_q == PORT_CMD);
  assign nand_ale   = nand_we && (port_q == PORT_ADDR);
  assign rsp_done   = (state == ST_DONE);
  assign rsp_rdata  = rsp_done ? acc : '0;
endmodule

// File: rtl/nwa_checker.sv
module nwa_checker #(
  parameter int DW = 32,
  parameter int BW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_done,
  input logic          nand_valid,
  input logic          nand_ready,
  input logic          nand_we,
  input logic          nand_cle,
  input logic          nand_ale,
  input logic [BW-1:0] nand_dout
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R9
  AST_DONE_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !nand_valid && !req_ready); // R9
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    nand_valid && !nand_ready |=> nand_valid && $stable(nand_dout)
      && $stable(nand_we) && $stable(nand_cle) && $stable(nand_ale)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !nand_valid && !rsp_done); // R1
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({nand_cle, nand_ale}) <= 1); // R6
  AST_FLAGS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cle || nand_ale) |-> nand_valid && nand_we); // R6
endmodule

bind nand_width_adapter nwa_checker #(.DW(DW), .BW(BW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .nand_valid(nand_valid),
  .nand_ready(nand_ready),
  .nand_we   (nand_we),
  .nand_cle  (nand_cle),
  .nand_ale  (nand_ale),
  .nand_dout (nand_dout)
);

// File: tb/nand_width_adapter_test.sv
module nand_width_adapter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  dev_cfg = 2'b00;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_port = 2'd0;
  logic [1:0]  req_size = 2'd0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic        nand_valid;
  logic        nand_ready = 1'b0;
  logic        nand_we, nand_cle, nand_ale;
  logic [15:0] nand_dout;
  logic [15:0] nand_din = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Follow-on request raised during the done cycle (overlap scenario)
  bit          nxt_en = 0;
  logic [1:0]  nxt_port, nxt_size;
  logic        nxt_write;

  always #10 clk = ~clk;

  nand_width_adapter uut (
    .clk(clk), .rst_n(rst_n), .dev_cfg(dev_cfg),
    .req_valid(req_valid), .req_ready(req_ready), .req_port(req_port),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .nand_valid(nand_valid), .nand_ready(nand_ready), .nand_we(nand_we),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_dout(nand_dout),
    .nand_din(nand_din)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int k);
    return 16'h5AC3 ^ (16'h1357 * 16'(k + 1));
  endfunction

  // One access end to end; stall = not-ready cycles on beat 0.
  task automatic xfer(input logic [1:0] cfg, input logic [1:0] port,
                      input logic [1:0] size, input logic wr,
                      input logic [31:0] wdata, input int stall,
                      input string req);
    bit wide = cfg[0];
    int nbytes = (size >= 2) ? 4 : (1 << size);
    int beats = wide ? (nbytes + 1) / 2 : nbytes;
    logic [31:0] exp_rd = '0;
    int k = 0;
    int st = stall;
    bit last_hs = 0;
    bit done_seen = 0;
    logic [15:0] exp_dout;
    logic exp_cle, exp_ale;
    exp_cle = wr && (port == 2'd1);
    exp_ale = wr && (port == 2'd2);
    if (!wr) begin
      for (int b = 0; b < beats; b++) begin
        if (wide && nbytes == 1) exp_rd = {24'h0, pat(0)[7:0]};
        else if (wide) exp_rd = exp_rd | ({16'h0, pat(b)} << (16 * b));
        else exp_rd = exp_rd | ({24'h0, pat(b)[7:0]} << (8 * b));
      end
    end
    dev_cfg = cfg; req_port = port; req_size = size;
    req_write = wr; req_wdata = wdata; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    dev_cfg = ~cfg & 2'b10 | (cfg & 2'b01) ^ 2'b00; // R7: upper bit toggled after accept
    for (int cyc = 0; cyc < 100 && !done_seen; cyc++) begin
      if (last_hs) begin
        check(rsp_done === 1'b1, "R9", "done after last beat", 32'(rsp_done), 32'h1);
        last_hs = 0;
      end
      if (rsp_done) begin
        done_seen = 1;
        nand_ready = 1'b0;
        check(k == beats, req, "beat count", 32'(k), 32'(beats));
        check(rsp_rdata === exp_rd, wr ? "R8" : req, "rdata", rsp_rdata, exp_rd);
        check(req_ready === 1'b0, "R1", "ready low in done", 32'(req_ready), 32'h0);
        if (nxt_en) begin
          req_port = nxt_port; req_size = nxt_size; req_write = nxt_write;
          req_valid = 1'b1;
        end
      end else if (nand_valid) begin
        if (wide) exp_dout = wdata[16*k +: 16];
        else exp_dout = {8'h00, wdata[8*k +: 8]};
        check(k < beats, req, "extra beat", 32'(k), 32'(beats));
        check(nand_we === wr, req, "we", 32'(nand_we), 32'(wr));
        check({nand_cle, nand_ale} === {exp_cle, exp_ale}, "R6", "cle/ale",
              32'({nand_cle, nand_ale}), 32'({exp_cle, exp_ale}));
        if (wr) check(nand_dout === exp_dout, req, "dout", 32'(nand_dout), 32'(exp_dout));
        if (st > 0) begin
          st--;
          nand_ready = 1'b0;
        end else begin
          nand_din = pat(k);
          nand_ready = 1'b1;
          k++;
          if (k == beats) last_hs = 1;
        end
      end else begin
        nand_ready = 1'b0;
      end
      @(negedge clk);
    end
    check(done_seen, "R9", "completion seen", 32'(done_seen), 32'h1);
    check(rsp_done === 1'b0, "R9", "done single cycle", 32'(rsp_done), 32'h0);
    if (nxt_en) check(req_ready === 1'b1, "R1", "ready after done", 32'(req_ready), 32'h1);
  endtask

  task automatic t_reset;
    check(req_ready === 1'b1, "R1", "reset ready", 32'(req_ready), 32'h1);
    check(nand_valid === 1'b0, "R1", "reset valid", 32'(nand_valid), 32'h0);
    check(rsp_done === 1'b0, "R9", "reset done", 32'(rsp_done), 32'h0);
  endtask

  task automatic t_narrow;
    xfer(2'b00, 2'd0, 2'd0, 1'b1, 32'hDEADBE71, 0, "R2");
    xfer(2'b00, 2'd0, 2'd1, 1'b1, 32'h1234A5C6, 0, "R2");
    xfer(2'b00, 2'd0, 2'd2, 1'b1, 32'h89ABCDEF, 2, "R2");
    xfer(2'b00, 2'd0, 2'd2, 1'b0, 32'h0, 1, "R8");
    xfer(2'b00, 2'd0, 2'd1, 1'b0, 32'h0, 0, "R8");
  endtask

  task automatic t_wide;
    xfer(2'b01, 2'd0, 2'd1, 1'b1, 32'hCAFE1234, 0, "R3");
    xfer(2'b01, 2'd0, 2'd2, 1'b1, 32'h0F1E2D3C, 3, "R3");
    xfer(2'b01, 2'd0, 2'd2, 1'b0, 32'h0, 0, "R3");
    xfer(2'b01, 2'd0, 2'd0, 1'b0, 32'h0, 0, "R4");
    xfer(2'b01, 2'd0, 2'd0, 1'b1, 32'h7777BEEF, 0, "R5");
  endtask

  task automatic t_flags;
    xfer(2'b00, 2'd1, 2'd0, 1'b1, 32'h00000070, 0, "R6");
    xfer(2'b00, 2'd2, 2'd2, 1'b1, 32'h00030201, 0, "R6");
    xfer(2'b01, 2'd3, 2'd1, 1'b1, 32'h0000ABCD, 0, "R6");
    xfer(2'b00, 2'd1, 2'd0, 1'b0, 32'h0, 0, "R6");
  endtask

  task automatic t_cfg_upper;
    xfer(2'b10, 2'd0, 2'd1, 1'b1, 32'h0000F00D, 0, "R7");
    xfer(2'b11, 2'd0, 2'd2, 1'b0, 32'h0, 0, "R7");
  endtask

  task automatic t_overlap;
    nxt_en = 1; nxt_port = 2'd0; nxt_size = 2'd2; nxt_write = 1'b0;
    xfer(2'b01, 2'd1, 2'd0, 1'b1, 32'h000000FF, 0, "R1");
    nxt_en = 0;
    xfer(2'b01, 2'd0, 2'd2, 1'b0, 32'h0, 1, "R1");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_narrow();
    t_wide();
    t_flags();
    t_cfg_upper();
    t_overlap();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule